// File: doc/BRIEF.md
# Page Buffer with Timed Commit

This block sits behind a two-wire serial protocol engine and in front of a 128-word, 8-bit storage array. It owns the one word-address counter that reads and writes share. Write data is not stored in the array straight away. Bytes collect in a four-entry page buffer. When the engine signals that the write transaction has ended, the buffered bytes are committed to the array during a self-timed write cycle. Busy is asserted for the whole of that cycle.

The counter follows two wrap rules:

- **Writes:** only the two low address bits advance, so a burst stays inside its four-word page. A fifth byte lands on top of the first.
- **Reads:** all seven bits advance, so one read transaction can stream the whole array. After the last word it continues at word 0.

In both cases the counter ends up pointing one past the word last touched. A read with no address phase therefore carries on from there.

While busy is high, every strobe from the engine is refused. This is what lets the engine answer address polls with no acknowledge. The array is a plain register memory. Its power-up contents come from a seed parameter so that tests can predict them.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy is 0, the counter is 0 and no buffer entry is valid. A read before any address load returns word 0.
- R2: An address-load strobe sets the counter to bits 6:0 of the data input. Bit 7 is ignored.
- R3: A write-byte strobe stores the data in buffer entry (counter bits 1:0) and marks that entry valid. It then increments only counter bits 1:0, so counter bits 6:2 are unchanged by writes.
- R4: A fifth or later write byte in one transaction wraps within the page and replaces the byte held for that entry. Only the newest byte per entry is committed.
- R5: The array is not changed by write bytes. An end-of-write strobe with at least one valid entry raises busy on the next cycle. Busy stays high for exactly WR_CYCLES cycles, and the array holds the new data when busy falls.
- R6: A commit writes only the entries marked valid, at the page given by counter bits 6:2. All other words keep their contents. The valid flags are clear after the commit.
- R7: An end-of-write strobe with no valid entry does not raise busy.
- R8: A read-byte strobe puts the word at the counter on the data output one cycle later. It then increments all seven counter bits, wrapping from 127 to 0.
- R9: The counter is shared. After writes, a read with no address phase starts at the address that follows the last written one, computed by the write wrap rule.
- R10: While busy is high, address-load, write-byte, read-byte and end-of-write strobes are ignored. The counter, the buffer and the data output do not change.
- R11: The data output changes only on an accepted read strobe.
- R12: When strobes coincide, end-of-write wins, then address-load, then write-byte, then read-byte. Only one action is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load the word-address counter from din |
| wr_byte | input | 1 | Buffer din as the next page-write byte |
| rd_byte | input | 1 | Read the word at the counter onto dout |
| wr_end | input | 1 | Write transaction ended; start the commit if data is buffered |
| din | input | 8 | Address or write data from the protocol engine |
| dout | output | 8 | Read data, registered |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The checker watches the commit timing on every cycle, at the block's ports:

- an end-of-write with buffered data starts busy;
- an end-of-write with nothing buffered leaves the block idle;
- busy lasts exactly WR_CYCLES;
- busy rises only after an end-of-write;
- the read data holds unless a read is accepted.

What lands in the array can only be shown by the bench's scenarios, which read it back. This covers the two counter wrap rules, the page overflow that replaces earlier bytes, commits that skip entries nothing was written to, and strobes issued during busy having no lasting effect.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 2;
    localparam int SLOTS  = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BASE_W = ADDR_W - PAGE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [PAGE_W-1:0] slot_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic finish;
    } cmd_t;

    // Write rule: page-local increment, upper bits held.
    function automatic addr_t wr_next(input addr_t a);
        return {a[ADDR_W-1:PAGE_W], slot_t'(a[PAGE_W-1:0] + 1'b1)};
    endfunction

    // Read rule: full-width increment, wraps at DEPTH.
    function automatic addr_t rd_next(input addr_t a);
        return addr_t'(a + 1'b1);
    endfunction

    // Priority: end-of-write, load, write, read. Nothing while busy.
    function automatic cmd_t decode(input logic busy, input logic ld,
                                    input logic wr, input logic rd,
                                    input logic fin);
        cmd_t c;
        c.op     = OP_NONE;
        c.finish = 1'b0;
        if (!busy) begin
            if (fin)     c.finish = 1'b1;
            else if (ld) c.op = OP_LOAD;
            else if (wr) c.op = OP_WRITE;
            else if (rd) c.op = OP_READ;
        end
        return c;
    endfunction

endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr
    import pcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  addr_t load_val,
    output addr_t cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                OP_LOAD:  cnt <= load_val;
                OP_WRITE: cnt <= wr_next(cnt);
                OP_READ:  cnt <= rd_next(cnt);
                default:  cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/pcb_page_buf.sv
module pcb_page_buf
    import pcb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  slot_t                   slot,
    input  byte_t                   wdata,
    input  logic                    clear,
    output byte_t [SLOTS-1:0]       data,
    output logic  [SLOTS-1:0]       valid,
    output logic                    any_valid
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid[s] <= 1'b0;
                data[s]  <= '0;
            end else if (clear) begin
                valid[s] <= 1'b0;
            end else if (wr_en && slot == slot_t'(s)) begin
                valid[s] <= 1'b1;
                data[s]  <= wdata;
            end
        end
    end

    assign any_valid = |valid;

endmodule

// File: rtl/pcb_wr_timer.sv
module pcb_wr_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)           remain <= '0;
        else if (start)    remain <= CW'(CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign done = (remain == CW'(1));

endmodule

// File: rtl/pcb_array.sv
module pcb_array
    import pcb_pkg::*;
#(
    parameter byte_t INIT_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  addr_t             rd_addr,
    output byte_t             rd_data,
    input  logic              commit,
    input  base_t             page,
    input  byte_t [SLOTS-1:0] cdata,
    input  logic  [SLOTS-1:0] cvalid
);

    byte_t mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = byte_t'(i * 3) + INIT_SEED;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (cvalid[s]) mem[{page, slot_t'(s)}] <= cdata[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pcb_pkg::*;
#(
    parameter int    WR_CYCLES = 50,
    parameter byte_t INIT_SEED = 8'h5A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_ld,
    input  logic        wr_byte,
    input  logic        rd_byte,
    input  logic        wr_end,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        busy
);

    cmd_t              cmd;
    addr_t             cnt;
    byte_t [SLOTS-1:0] bdata;
    logic  [SLOTS-1:0] bvalid;
    logic              any_valid;
    logic              done;
    logic              start;

    assign cmd   = decode(busy, addr_ld, wr_byte, rd_byte, wr_end);
    assign start = cmd.finish && any_valid;

    pcb_addr_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .op       (cmd.op),
        .load_val (din[ADDR_W-1:0]),
        .cnt      (cnt)
    );

    pcb_page_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cmd.op == OP_WRITE),
        .slot      (cnt[PAGE_W-1:0]),
        .wdata     (din),
        .clear     (done),
        .data      (bdata),
        .valid     (bvalid),
        .any_valid (any_valid)
    );

    pcb_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    pcb_array #(.INIT_SEED(INIT_SEED)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (cmd.op == OP_READ),
        .rd_addr (cnt),
        .rd_data (dout),
        .commit  (done),
        .page    (cnt[ADDR_W-1:PAGE_W]),
        .cdata   (bdata),
        .cvalid  (bvalid)
    );

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int WR_CYCLES = 50
) (
    input logic       clk,
    input logic       rst,
    input logic       addr_ld,
    input logic       wr_byte,
    input logic       rd_byte,
    input logic       wr_end,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       busy
);

    int   run;
    logic pending;
    logic rd_take;

    assign rd_take = rd_byte && !busy && !wr_end && !addr_ld && !wr_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 0;
            pending <= 1'b0;
        end else begin
            run <= busy ? run + 1 : 0;
            if (busy)
                pending <= 1'b0;
            else if (wr_byte && !wr_end && !addr_ld)
                pending <= 1'b1;
        end
    end

    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_end && pending) |=> busy); // R5
    AST_EMPTY_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_end && !pending) |=> !busy); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && run < WR_CYCLES - 1) |=> busy); // R5
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && run >= WR_CYCLES - 1) |=> !busy); // R5
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_end)); // R10
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_take |=> $stable(dout)); // R11

    logic unused_din;
    assign unused_din = ^din;

endmodule

bind page_commit_buf pcb_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr_ld (addr_ld),
    .wr_byte (wr_byte),
    .rd_byte (rd_byte),
    .wr_end  (wr_end),
    .din     (din),
    .dout    (dout),
    .busy    (busy)
);

// File: tb/tb_page_commit_buf.sv
module tb_page_commit_buf;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 50;
    localparam logic [7:0] SEED = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_ld = 1'b0, wr_byte = 1'b0, rd_byte = 1'b0, wr_end = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       busy;

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl [128];
    logic [6:0] mcnt;
    logic [7:0] mbuf [4];
    logic [3:0] mval;
    logic       take = 1'b0;
    logic [7:0] expq [$];
    string      tagq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_commit_buf #(.WR_CYCLES(W), .INIT_SEED(SEED)) dut (
        .clk(clk), .rst(rst), .addr_ld(addr_ld), .wr_byte(wr_byte),
        .rd_byte(rd_byte), .wr_end(wr_end), .din(din), .dout(dout), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected byte per accepted read.
    always @(posedge clk) begin
        if (rd_byte && take) begin
            #1;
            chk(tagq.pop_front(), dout, expq.pop_front());
        end
    end

    task automatic pulse(input logic l, input logic w, input logic r,
                         input logic e, input logic [7:0] d);
        addr_ld = l; wr_byte = w; rd_byte = r; wr_end = e; din = d;
        @(negedge clk);
        addr_ld = 0; wr_byte = 0; rd_byte = 0; wr_end = 0; take = 0;
    endtask

    task automatic ld(input logic [7:0] a);
        mcnt = a[6:0];
        pulse(1, 0, 0, 0, a);
    endtask

    task automatic wb(input logic [7:0] d);
        mbuf[mcnt[1:0]] = d;
        mval[mcnt[1:0]] = 1'b1;
        mcnt = {mcnt[6:2], 2'(mcnt[1:0] + 2'd1)};
        pulse(0, 1, 0, 0, d);
    endtask

    task automatic rd(input string tag);
        expq.push_back(mdl[mcnt]);
        tagq.push_back(tag);
        mcnt = 7'(mcnt + 7'd1);
        take = 1'b1;
        pulse(0, 0, 1, 0, 8'h00);
    endtask

    // End of write; if poke, fire ignored strobes during busy (R10).
    task automatic fin(input string tag, input bit poke);
        int n;
        logic [7:0] held;
        bit had = |mval;
        pulse(0, 0, 0, 1, 8'h00);
        if (!had) begin
            chk({tag, " R7 no busy"}, busy, 0);
        end else begin
            chk({tag, " R5 busy rises"}, busy, 1);
            n = 0;
            held = dout;
            while (busy && n < 4 * W) begin
                n++;
                if (poke && n == 3) pulse(1, 0, 0, 0, 8'h70);
                else if (poke && n == 5) pulse(0, 1, 0, 0, 8'hEE);
                else if (poke && n == 7) pulse(0, 0, 1, 0, 8'h00);
                else if (poke && n == 9) pulse(0, 0, 0, 1, 8'h00);
                else @(negedge clk);
            end
            chk({tag, " R5 busy length"}, n, W);
            if (poke) chk({tag, " R10 dout held"}, dout, held);
            for (int s = 0; s < 4; s++)
                if (mval[s]) mdl[{mcnt[6:2], 2'(s)}] = mbuf[s];
            mval = '0;
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = 8'(i * 3) + SEED;
        mcnt = '0;
        mval = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 dout after reset", dout, 0);
        fin("reset end", 0);                 // R7 empty end-of-write
        rd("R1 read word 0 after reset");
        chk("R11 dout held idle", dout, mdl[0]);

        ld(8'h85);                            // R2 bit 7 ignored
        rd("R2 load ignores bit7");
        rd("R8 sequential 6");
        rd("R8 sequential 7");

        ld(8'd126);
        rd("R8 read 126");
        rd("R8 read 127");
        rd("R8 wrap to 0");

        // R5: buffered byte not yet in array.
        ld(8'h20);
        wb(8'hC3);
        ld(8'h20);
        rd("R5 array untouched before commit");
        fin("single", 0);
        ld(8'h20);
        rd("R5 committed byte");
        rd("R6 neighbour unchanged");

        // R3/R6/R9 partial page at 0x12.
        ld(8'h12);
        wb(8'hA1);
        wb(8'hB2);
        fin("partial", 0);
        rd("R9 R3 continue at 0x10");
        rd("R6 0x11 unchanged");
        rd("R3 slot2 data");
        rd("R3 slot3 data");

        // R4 overflow of five bytes, with strobes during busy (R10).
        ld(8'h40);
        wb(8'h01); wb(8'h02); wb(8'h03); wb(8'h04); wb(8'h05);
        fin("overflow", 1);
        rd("R10 R9 counter kept at 0x41");
        fin("after busy", 0);                // R10 ignored write left nothing
        ld(8'h40);
        rd("R4 slot0 overwritten");
        rd("R4 slot1");
        rd("R4 slot2");
        rd("R4 slot3");

        // R12: load beats write and read in one cycle.
        addr_ld = 1; wr_byte = 1; rd_byte = 1; din = 8'h33;
        @(negedge clk);
        addr_ld = 0; wr_byte = 0; rd_byte = 0;
        mcnt = 7'h33;
        fin("R12 priority", 0);
        rd("R12 load won");

        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule